// File: doc/BRIEF.md
# High-Side Channel Gate Guard

This block governs one output channel of a high-side gate driver. It merges a discrete request pin with a serial gate bit into a gate command. The command is qualified by a driver enable, two supply undervoltage flags and the channel's own latched faults. It then drives a single digital gate-on line. Each change of the gate line starts a programmable blanking window, so switching transients do not trip the fault monitor.

Once the window has run out, the block watches three digital comparator outputs, each passed through a two-flop synchronizer. While the gate is on it watches the drain-source short indication through a short consecutive-cycle filter. While the gate is off it watches the source-high indication and the open-load indication. Detected faults are latched. A short while on always forces the gate off. The two off-state faults inhibit the gate unless masked. A clear input drops every latched fault, after which a fault that is still present is caught again. Analog sensing is outside the block; it sees only digital comparator levels and drives only digital enables.

Top module: `hsg_chan_guard`

## Requirements
- R1: `gate_on` equals `pin_cmd OR ser_gate` in the same cycle (no register in the path) whenever the channel is permitted to drive.
- R2: `drv_en` low, `cp_uv` high or `logic_uv` high each force `gate_on` to 0 in the same cycle.
- R3: Every change of `gate_on` starts a blanking window whose length is chosen by `blank_sel`, sampled at the first rising edge after the change: 00 = 12, 01 = 20, 10 = 32, 11 = 60 cycles. The same length applies to turn-on and turn-off.
- R4: With the gate off and the synchronized `cmp_stb` (or `cmp_ol`) steady high, `flt_stb` (or `flt_ol`) is 0 after the first N rising edges following the turn-off and 1 after edge N+1, where N is the blank length.
- R5: A latched `flt_stb` or `flt_ol` holds `gate_on` at 0 while `mask_off` is 0.
- R6: With the gate on and the synchronized `cmp_stg` steady high, `flt_stg` sets after edge N+4 following turn-on (blank plus 4 consecutive sampled cycles) and `gate_on` falls in that same cycle; `flt_stg` is 0 and the gate still on after edge N+3.
- R7: While `mask_off` is 1, the short-to-battery and open-load faults are neither latched nor inhibiting; the short-to-ground fault is detected and acts exactly as in R6.
- R8: `clr_flt` high at a rising edge clears all three fault flags at that edge, taking priority over detection. The gate then follows its command again, and a fault still present is re-detected after a fresh blank window.
- R9: `ol_bias_en` is 1 exactly when `pin_cmd OR ser_gate` is 0.
- R10: While `rst_n` is low at a rising edge, all fault flags are 0 and the blank timer holds the settled-off state.
- R11: A comparator change arriving between edges j-1 and j reaches the fault logic through two flops: with the gate settled off, a rise of `cmp_stb` gives `flt_stb` = 0 after edges j and j+1 and 1 after edge j+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 4 MHz system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_cmd | input | 1 | Discrete gate request pin |
| ser_gate | input | 1 | Gate bit from the serial register |
| blank_sel | input | 2 | Blank length select (00 = 12, 01 = 20, 10 = 32, 11 = 60 cycles) |
| mask_off | input | 1 | Ignore off-state faults when 1 |
| clr_flt | input | 1 | Clear latched faults when 1 at a clock edge |
| drv_en | input | 1 | Driver enable, low forces the gate off |
| cp_uv | input | 1 | Charge-pump undervoltage, high forces the gate off |
| logic_uv | input | 1 | Logic-supply undervoltage, high forces the gate off |
| cmp_stg | input | 1 | Asynchronous drain-source short comparator |
| cmp_stb | input | 1 | Asynchronous source-high comparator |
| cmp_ol | input | 1 | Asynchronous open-load comparator |
| gate_on | output | 1 | Gate drive command |
| ol_bias_en | output | 1 | Open-load bias source enable |
| flt_stg | output | 1 | Latched short-to-ground fault |
| flt_stb | output | 1 | Latched short-to-battery fault |
| flt_ol | output | 1 | Latched open-load fault |

## Verification
The hardest case to reach from the ports is the exact cycle in which a blank window closes while a comparator is already active. The bench holds the comparator high before the gate edge, which takes the synchronizer latency out of the count. It then counts rising edges from the gate change and samples one edge before and one edge after the expected latch. Re-detection after a clear is reached by keeping the short comparator high through the clear pulse. The gate then turns back on, a new window runs with a different length select, and the fault returns on a predicted edge.

// File: rtl/hsg_pkg.sv
// Package: shared types for the channel gate guard.
// Assumes: one fault record per channel, three load-fault kinds.
package hsg_pkg;
    typedef struct packed {
        logic stg;
        logic stb;
        logic ol;
    } hsg_flt_t;

    localparam int HSG_NCMP = 3;
    localparam int HSG_IDX_STG = 2;
    localparam int HSG_IDX_STB = 1;
    localparam int HSG_IDX_OL  = 0;
endpackage

// File: rtl/hsg_sync.sv
// Module: multi-stage synchronizer for asynchronous comparator levels.
// Assumes: each bit is an independent level; no bus coherence needed.
module hsg_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [STAGES-1:0][W-1:0] chain;

    // Shift the asynchronous levels through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= d_async;
            for (int s = 1; s < STAGES; s++) begin
                chain[s] <= chain[s-1];
            end
        end
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/hsg_blank_timer.sv
// Module: blanking window timer for one gate line.
// Assumes: every change of 'gate' restarts the window; the length is
// picked from four parameters by 'sel' at the first edge after the change.
module hsg_blank_timer #(
    parameter int B0 = 12,
    parameter int B1 = 20,
    parameter int B2 = 32,
    parameter int B3 = 60
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       gate,
    input  logic [1:0] sel,
    output logic       mon_on,
    output logic       mon_off
);
    localparam int BMAX12 = (B0 > B1) ? B0 : B1;
    localparam int BMAX34 = (B2 > B3) ? B2 : B3;
    localparam int BMAX   = (BMAX12 > BMAX34) ? BMAX12 : BMAX34;
    localparam int CW     = $clog2(BMAX + 1);

    logic          gate_seen;
    logic [CW-1:0] remain;
    logic [CW-1:0] load_val;
    logic          settled;

    // Pick the window length for the selected setting.
    always_comb begin
        unique case (sel)
            2'b00:   load_val = CW'(B0 - 1);
            2'b01:   load_val = CW'(B1 - 1);
            2'b10:   load_val = CW'(B2 - 1);
            default: load_val = CW'(B3 - 1);
        endcase
    end

    // Track the last seen gate level and count the window down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_seen <= 1'b0;
            remain    <= '0;
        end else if (gate != gate_seen) begin
            gate_seen <= gate;
            remain    <= load_val;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign settled = (remain == '0) && (gate_seen == gate);
    assign mon_on  = settled && gate;
    assign mon_off = settled && !gate;

    // A gate change must open a window on the next cycle (R3).
    assert_edge_opens_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (gate != gate_seen) |=> !(mon_on || mon_off));

    // The counter never exceeds the longest configured window (R3).
    assert_window_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        remain <= CW'(BMAX - 1));
endmodule

// File: rtl/hsg_fault_latch.sv
// Module: fault detection, filtering and latching for one channel.
// Assumes: comparator inputs are already synchronized; mon_on/mon_off
// come from the blank timer and are never both high.
module hsg_fault_latch
    import hsg_pkg::*;
#(
    parameter int FILT = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     mon_on,
    input  logic     mon_off,
    input  logic     stg_s,
    input  logic     stb_s,
    input  logic     ol_s,
    input  logic     mask,
    input  logic     clr,
    output hsg_flt_t flags
);
    localparam int FW = (FILT > 1) ? $clog2(FILT) : 1;

    logic [FW-1:0] fcnt;
    logic          stg_cond;

    assign stg_cond = mon_on && stg_s;

    // Latch faults; clear wins over detection in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
            fcnt  <= '0;
        end else if (clr) begin
            flags <= '0;
            fcnt  <= '0;
        end else begin
            if (stg_cond) begin
                if (fcnt == FW'(FILT - 1)) begin
                    flags.stg <= 1'b1;
                end else begin
                    fcnt <= fcnt + 1'b1;
                end
            end else begin
                fcnt <= '0;
            end
            if (mon_off && !mask && stb_s) begin
                flags.stb <= 1'b1;
            end
            if (mon_off && !mask && ol_s) begin
                flags.ol <= 1'b1;
            end
        end
    end

    // A new short-to-ground fault only follows a monitored, asserted sample (R6).
    assert_stg_needs_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags.stg) |-> ($past(stg_s) && $past(mon_on)));

    // Masking keeps a clear short-to-battery flag clear (R7).
    assert_mask_blocks_stb_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mask && !flags.stb) |=> !flags.stb);

    // Masking keeps a clear open-load flag clear (R7).
    assert_mask_blocks_ol_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mask && !flags.ol) |=> !flags.ol);

    // A clear leaves every flag low on the next cycle (R8).
    assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (flags == '0));
endmodule

// File: rtl/hsg_chan_guard.sv
// Module: per-channel gate control and load-fault monitor (top).
// Assumes: 4 MHz clock; comparator inputs are asynchronous digital levels;
// enable and undervoltage flags are already synchronous to clk.
module hsg_chan_guard
    import hsg_pkg::*;
#(
    parameter int BLANK0   = 12,
    parameter int BLANK1   = 20,
    parameter int BLANK2   = 32,
    parameter int BLANK3   = 60,
    parameter int STG_FILT = 4,
    parameter int SYNC_LEN = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_cmd,
    input  logic       ser_gate,
    input  logic [1:0] blank_sel,
    input  logic       mask_off,
    input  logic       clr_flt,
    input  logic       drv_en,
    input  logic       cp_uv,
    input  logic       logic_uv,
    input  logic       cmp_stg,
    input  logic       cmp_stb,
    input  logic       cmp_ol,
    output logic       gate_on,
    output logic       ol_bias_en,
    output logic       flt_stg,
    output logic       flt_stb,
    output logic       flt_ol
);
    logic [HSG_NCMP-1:0] cmp_raw;
    logic [HSG_NCMP-1:0] cmp_s;
    logic                cmd;
    logic                permit;
    logic                mon_on;
    logic                mon_off;
    hsg_flt_t            flags;

    assign cmp_raw[HSG_IDX_STG] = cmp_stg;
    assign cmp_raw[HSG_IDX_STB] = cmp_stb;
    assign cmp_raw[HSG_IDX_OL]  = cmp_ol;

    hsg_sync #(.W(HSG_NCMP), .STAGES(SYNC_LEN)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (cmp_raw),
        .q_sync  (cmp_s)
    );

    // Form the command and qualify it with enables and latched faults.
    always_comb begin
        cmd    = pin_cmd | ser_gate;
        permit = drv_en && !cp_uv && !logic_uv && !flags.stg &&
                 !((flags.stb || flags.ol) && !mask_off);
    end

    assign gate_on    = cmd && permit;
    assign ol_bias_en = !cmd;

    hsg_blank_timer #(.B0(BLANK0), .B1(BLANK1), .B2(BLANK2), .B3(BLANK3)) u_blank (
        .clk     (clk),
        .rst_n   (rst_n),
        .gate    (gate_on),
        .sel     (blank_sel),
        .mon_on  (mon_on),
        .mon_off (mon_off)
    );

    hsg_fault_latch #(.FILT(STG_FILT)) u_flt (
        .clk     (clk),
        .rst_n   (rst_n),
        .mon_on  (mon_on),
        .mon_off (mon_off),
        .stg_s   (cmp_s[HSG_IDX_STG]),
        .stb_s   (cmp_s[HSG_IDX_STB]),
        .ol_s    (cmp_s[HSG_IDX_OL]),
        .mask    (mask_off),
        .clr     (clr_flt),
        .flags   (flags)
    );

    assign flt_stg = flags.stg;
    assign flt_stb = flags.stb;
    assign flt_ol  = flags.ol;

    // The gate is never on without a request (R1).
    assert_gate_needs_cmd_R1: assert property (@(posedge clk) disable iff (!rst_n)
        gate_on |-> (pin_cmd || ser_gate));

    // Shutdown inputs keep the gate off (R2).
    assert_shutdown_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!drv_en || cp_uv || logic_uv) |-> !gate_on);

    // Unmasked off-state faults inhibit the gate (R5).
    assert_offfault_inhibits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((flt_stb || flt_ol) && !mask_off) |-> !gate_on);

    // A latched short-to-ground fault keeps the gate off (R6).
    assert_stg_forces_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flt_stg |-> !gate_on);

    // The bias source is never on together with the gate (R9).
    assert_bias_only_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ol_bias_en |-> !gate_on);
endmodule

// File: tb/test_hsg_chan_guard.sv
module test_hsg_chan_guard;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_cmd = 1'b0, ser_gate = 1'b0;
    logic [1:0] blank_sel = 2'b00;
    logic       mask_off = 1'b0, clr_flt = 1'b0;
    logic       drv_en = 1'b1, cp_uv = 1'b0, logic_uv = 1'b0;
    logic       cmp_stg = 1'b0, cmp_stb = 1'b0, cmp_ol = 1'b0;
    logic       gate_on, ol_bias_en, flt_stg, flt_stb, flt_ol;

    int compared   = 0;
    int mismatched = 0;
    int cyc        = 0;

    localparam int BL[4] = '{12, 20, 32, 60};
    localparam int FILT  = 4;

    // {pin, ser, en, cp_uv, logic_uv, exp_gate, exp_bias}
    localparam logic [6:0] VEC[8] = '{
        7'b00100_01, 7'b10100_10, 7'b01100_10, 7'b11100_10,
        7'b11000_00, 7'b10110_00, 7'b01101_00, 7'b00011_01
    };

    hsg_chan_guard i_hsg_chan_guard (
        .clk(clk), .rst_n(rst_n), .pin_cmd(pin_cmd), .ser_gate(ser_gate),
        .blank_sel(blank_sel), .mask_off(mask_off), .clr_flt(clr_flt),
        .drv_en(drv_en), .cp_uv(cp_uv), .logic_uv(logic_uv),
        .cmp_stg(cmp_stg), .cmp_stb(cmp_stb), .cmp_ol(cmp_ol),
        .gate_on(gate_on), .ol_bias_en(ol_bias_en),
        .flt_stg(flt_stg), .flt_stb(flt_stb), .flt_ol(flt_ol)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_pulse();
        clr_flt = 1'b1;
        tick(1);
        clr_flt = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        // R10: reset state
        tick(3);
        chk("R10 reset flags", {flt_stg, flt_stb, flt_ol}, 3'b000);
        chk("R10 reset gate", gate_on, 1'b0);
        chk("R9 reset bias", ol_bias_en, 1'b1);
        rst_n = 1'b1;
        tick(2);

        // R1 R2 R9: table of combinational gate cases
        for (int i = 0; i < 8; i++) begin
            {pin_cmd, ser_gate, drv_en, cp_uv, logic_uv} = VEC[i][6:2];
            #1;
            chk("R1 R2 table gate", gate_on, VEC[i][1]);
            chk("R9 table bias", ol_bias_en, VEC[i][0]);
            tick(1);
        end
        {pin_cmd, ser_gate, cp_uv, logic_uv} = 4'b0000;
        drv_en = 1'b1;
        tick(3);

        // R4: short-to-battery timing with blank setting 00
        blank_sel = 2'b00;
        cmp_stb = 1'b1;
        pin_cmd = 1'b1;
        tick(5);
        chk("R4 no stb while on", flt_stb, 1'b0);
        pin_cmd = 1'b0;
        tick(BL[0]);
        chk("R4 stb blanked", flt_stb, 1'b0);
        tick(1);
        chk("R4 stb latched", flt_stb, 1'b1);

        // R5: latched stb inhibits the gate
        pin_cmd = 1'b1;
        #1;
        chk("R5 inhibited", gate_on, 1'b0);

        // R7: mask lifts the inhibit; R8 clear while masked
        mask_off = 1'b1;
        #1;
        chk("R7 mask lifts inhibit", gate_on, 1'b1);
        clear_pulse();
        chk("R8 clear stb", flt_stb, 1'b0);
        pin_cmd = 1'b0;
        tick(BL[0] + 6);
        chk("R7 masked stb ignored", flt_stb, 1'b0);
        cmp_stb = 1'b0;
        tick(4);

        // R6 R7: short-to-ground with blank 11, mask still set
        blank_sel = 2'b11;
        cmp_stg = 1'b1;
        tick(4);
        pin_cmd = 1'b1;
        tick(BL[3] + FILT - 1);
        chk("R6 stg not yet", flt_stg, 1'b0);
        chk("R6 gate still on", gate_on, 1'b1);
        tick(1);
        chk("R7 stg latched under mask", flt_stg, 1'b1);
        chk("R6 gate forced off", gate_on, 1'b0);

        // R8: clear with fault present -> re-detection using blank 01
        blank_sel = 2'b01;
        clear_pulse();
        chk("R8 stg cleared", flt_stg, 1'b0);
        chk("R8 gate follows again", gate_on, 1'b1);
        tick(BL[1] + FILT - 1);
        chk("R8 stg before redetect", flt_stg, 1'b0);
        tick(1);
        chk("R8 stg redetected", flt_stg, 1'b1);

        // R3 R4: open load with blank 10 and mask cleared
        cmp_stg = 1'b0;
        pin_cmd = 1'b0;
        mask_off = 1'b0;
        tick(4);
        clear_pulse();
        blank_sel = 2'b10;
        cmp_ol = 1'b1;
        pin_cmd = 1'b1;
        tick(3);
        pin_cmd = 1'b0;
        tick(BL[2]);
        chk("R3 ol blanked 32", flt_ol, 1'b0);
        tick(1);
        chk("R4 ol latched", flt_ol, 1'b1);
        chk("R4 stb not set", flt_stb, 1'b0);

        // R11: synchronizer latency with gate settled off
        cmp_ol = 1'b0;
        tick(4);
        clear_pulse();
        tick(3);
        cmp_stb = 1'b1;
        tick(1);
        chk("R11 stage 1", flt_stb, 1'b0);
        tick(1);
        chk("R11 stage 2", flt_stb, 1'b0);
        tick(1);
        chk("R11 latched", flt_stb, 1'b1);

        // R10: reset clears latched faults
        rst_n = 1'b0;
        tick(2);
        chk("R10 reset clears", {flt_stg, flt_stb, flt_ol}, 3'b000);
        rst_n = 1'b1;
        cmp_stb = 1'b0;
        tick(2);

        // R2: undervoltage shutdown with a live request
        pin_cmd = 1'b1;
        #1;
        chk("R2 on before uv", gate_on, 1'b1);
        cp_uv = 1'b1;
        #1;
        chk("R2 cp uv off", gate_on, 1'b0);
        cp_uv = 1'b0;
        logic_uv = 1'b1;
        #1;
        chk("R2 logic uv off", gate_on, 1'b0);
        logic_uv = 1'b0;
        tick(1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule